// File: doc/BRIEF.md
# Restricted-Ratio Reference Divider

This block divides a reference clock by a programmed ratio. The result is a clock-rate enable and a square-wave level that pace a serial receiver and transmitter at a nominal 1 MHz. Only five ratios are honoured: 1, 2, 4, 8 and 10. Any other programmed value silences both divided outputs. The block does not approximate an illegal ratio.

A single strobe loads the ratio register. The register value is always visible on a readback port, exactly as it was written, even when the value is illegal. Each write restarts the internal count, so the new ratio begins cleanly with the next cycle.

A select input chooses what drives the serial enable. When the select is high, the divided enable drives it. When the select is low, an externally supplied bypass enable drives it.

Top module: `rdiv_top`

## Requirements
- R1: `ratio_o` always shows the last value loaded through `wr_ratio_i` while `wr_en_i` was high, bit for bit. This holds for illegal values too.
- R2: Only the ratio codes 8'h01, 8'h02, 8'h04, 8'h08 and 8'h0A are legal. While any other code is held, including 8'h00, `tick_o` and `wave_o` stay low on every cycle.
- R3: After reset the ratio register reads 8'h00, and `tick_o` and `wave_o` are low until a legal ratio is written.
- R4: With ratio 8'h01, `tick_o` and `wave_o` are high on every cycle after the write.
- R5: With an even legal ratio N, `tick_o` is high for exactly one cycle in every N. That cycle is the Nth cycle after the loading edge, and every Nth cycle after that.
- R6: With an even legal ratio N, `wave_o` is high for N/2 cycles and then low for N/2 cycles. For ratio 10 that means 5 high and 5 low.
- R7: A write restarts the period. In the first cycle after the loading edge, `wave_o` is high and the count is at its start, whatever phase the old ratio was in.
- R8: `ser_en_o` equals `tick_o` while `sel_div_i` is 1, and equals `byp_en_i` while `sel_div_i` is 0. The switch is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Ratio load strobe |
| wr_ratio_i | input | 8 | Ratio value to load |
| sel_div_i | input | 1 | 1 selects the divided enable, 0 selects the bypass |
| byp_en_i | input | 1 | Bypass enable |
| ratio_o | output | 8 | Readback of the ratio register |
| tick_o | output | 1 | One-cycle enable at the divided rate |
| wave_o | output | 1 | Divided square-wave level |
| ser_en_o | output | 1 | Enable delivered to the serial logic |

## Verification
The hardest state to reach is a rewrite that lands mid-period. The count of one ratio must be cut short and a new ratio must begin from its start. A wrong restart only shows up as a phase error several cycles later. The stimulus therefore writes new ratios at several offsets inside a running period, including legal-to-illegal and illegal-to-legal changes. A cycle-by-cycle behavioural model is compared against all four outputs on every clock.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   localparam int unsigned NUM_LEGAL = 5;

   function automatic int unsigned legal_code(int unsigned idx);
      case (idx)
         0:       legal_code = 1;
         1:       legal_code = 2;
         2:       legal_code = 4;
         3:       legal_code = 8;
         default: legal_code = 10;
      endcase
   endfunction

endpackage

// File: rtl/rdiv_decode.sv
module rdiv_decode #(
   parameter int unsigned W  = 8,
   parameter int unsigned CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [W-1:0]  wr_ratio_i,
   output logic [W-1:0]  ratio_o,
   output logic          legal_o,
   output logic          unity_o,
   output logic [CW-1:0] last_o,
   output logic [CW-1:0] half_o
);
   localparam int unsigned NL = rdiv_pkg::NUM_LEGAL;

   logic [W-1:0]  ratio_q;
   logic [NL-1:0] hit;
   logic [W-1:0]  ratio_m1;
   logic [W-1:0]  ratio_h;

   if (W < 4) begin : g_w_check
      $error("rdiv_decode: W must hold the value 10");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      ratio_q <= '0;
      else if (wr_en_i) ratio_q <= wr_ratio_i;
   end

   for (genvar g = 0; g < NL; g++) begin : g_hit
      assign hit[g] = (ratio_q == W'(rdiv_pkg::legal_code(g)));
   end

   assign ratio_m1 = ratio_q - W'(1);
   assign ratio_h  = ratio_q >> 1;
   assign legal_o  = |hit;
   assign unity_o  = hit[0];
   assign last_o   = ratio_m1[CW-1:0];
   assign half_o   = ratio_h[CW-1:0];
   assign ratio_o  = ratio_q;

   a_r1_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_en_i) |-> ratio_o == $past(wr_ratio_i));
endmodule

// File: rtl/rdiv_count.sv
module rdiv_count #(
   parameter int unsigned CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          restart_i,
   input  logic          run_i,
   input  logic          unity_i,
   input  logic [CW-1:0] last_i,
   input  logic [CW-1:0] half_i,
   output logic          tick_o,
   output logic          wave_o
);
   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q == last_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (restart_i)   cnt_q <= '0;
      else if (!run_i)      cnt_q <= '0;
      else if (at_end)      cnt_q <= '0;
      else                  cnt_q <= cnt_q + CW'(1);
   end

   assign tick_o = run_i && at_end;
   assign wave_o = run_i && (unity_i || (cnt_q < half_i));

   a_r7_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> cnt_q == '0);
   a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> cnt_q <= last_i);
endmodule

// File: rtl/rdiv_select.sv
module rdiv_select (
   input  logic sel_div_i,
   input  logic div_en_i,
   input  logic byp_en_i,
   output logic ser_en_o
);
   assign ser_en_o = sel_div_i ? div_en_i : byp_en_i;
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
   parameter int unsigned W         = 8,
   parameter int unsigned MAX_RATIO = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_ratio_i,
   input  logic         sel_div_i,
   input  logic         byp_en_i,
   output logic [W-1:0] ratio_o,
   output logic         tick_o,
   output logic         wave_o,
   output logic         ser_en_o
);
   localparam int unsigned CW = $clog2(MAX_RATIO);

   if (MAX_RATIO < 10) begin : g_max_check
      $error("rdiv_top: MAX_RATIO must cover the largest legal ratio");
   end

   logic          legal;
   logic          unity;
   logic [CW-1:0] last;
   logic [CW-1:0] half;

   rdiv_decode #(.W(W), .CW(CW)) u_decode (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_ratio_i(wr_ratio_i),
      .ratio_o(ratio_o), .legal_o(legal), .unity_o(unity), .last_o(last), .half_o(half)
   );

   rdiv_count #(.CW(CW)) u_count (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(wr_en_i), .run_i(legal),
      .unity_i(unity), .last_i(last), .half_i(half), .tick_o(tick_o), .wave_o(wave_o)
   );

   rdiv_select u_select (
      .sel_div_i(sel_div_i), .div_en_i(tick_o), .byp_en_i(byp_en_i), .ser_en_o(ser_en_o)
   );

   a_r2_illegal_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !legal |-> (!tick_o && !wave_o));
   a_r5_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && !unity && !wr_en_i) |=> !tick_o);
   a_r4_unity_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unity && !wr_en_i) |=> (tick_o && wave_o));
endmodule

// File: tb/rdiv_top_tb.sv
module rdiv_top_tb;
   logic       clk_i = 0;
   logic       rst_ni = 0;
   logic       wr_en_i = 0;
   logic [7:0] wr_ratio_i = 0;
   logic       sel_div_i = 1;
   logic       byp_en_i = 0;
   logic [7:0] ratio_o;
   logic       tick_o, wave_o, ser_en_o;

   int checks = 0;
   int errors = 0;
   int mrat = 0;
   int mcnt = 0;
   bit after_wr = 0;

   always #2.5 clk_i = ~clk_i;

   rdiv_top u_dut (.*);

   function automatic bit is_legal(int r);
      return r == 1 || r == 2 || r == 4 || r == 8 || r == 10;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(bit we, int data, bit sel, bit byp);
      bit et, ew;
      string rq;
      wr_en_i = we; wr_ratio_i = 8'(data); sel_div_i = sel; byp_en_i = byp;
      #1;
      et = is_legal(mrat) && (mcnt == mrat - 1);
      ew = (mrat == 1) || (is_legal(mrat) && mcnt < mrat / 2);
      if (!is_legal(mrat)) rq = "R2";
      else if (mrat == 1)  rq = "R4";
      else if (after_wr)   rq = "R7";
      else                 rq = "R5";
      chk(rq, tick_o, et);
      chk(mrat == 1 || !is_legal(mrat) || after_wr ? rq : "R6", wave_o, ew);
      chk("R8", ser_en_o, sel ? et : byp);
      chk("R1", ratio_o, mrat & 8'hFF);
      @(posedge clk_i);
      if (we) begin mrat = data; mcnt = 0; end
      else if (is_legal(mrat)) mcnt = (mcnt == mrat - 1) ? 0 : mcnt + 1;
      else mcnt = 0;
      after_wr = we;
      @(negedge clk_i);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(0, 0, i % 3 != 0, i % 2);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1;
      #1;
      chk("R3", ratio_o, 0);
      chk("R3", tick_o, 0);
      chk("R3", wave_o, 0);
      run(6);
      step(1, 10, 1, 0); run(23);
      step(1, 2, 1, 0);  run(7);
      step(1, 4, 1, 1);  run(2);
      step(1, 8, 1, 0);  run(5);
      step(1, 8'h0A, 1, 0); run(3);
      step(1, 3, 0, 1);  run(8);
      step(1, 1, 1, 0);  run(6);
      step(1, 8'hFF, 1, 0); run(5);
      step(1, 4, 1, 0);  run(9);
      step(1, 0, 1, 0);  run(4);
      step(1, 8, 0, 1);  run(19);
      step(1, 9, 1, 0);  run(4);
      step(1, 10, 1, 1); run(12);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule